// File: doc/BRIEF.md
# Word-Serial Lightweight Cipher Encryptor

This block encrypts one 64-bit block with the PRESENT lightweight cipher under an 80-bit key. It is reached through a narrow command port. Each clock, a 4-bit command picks one action and a 32-bit data word goes with it. Key and plaintext are staged in pieces through that port. A run command starts the computation. Once the ready flag is up, the two halves of the ciphertext are fetched one after the other.

The engine does one cipher round per clock. It runs 31 rounds and then a final whitening step, so the result is available 32 clocks after the run command. While a run is under way, the staging registers are locked against writes, so the computation in progress cannot be disturbed. Staged values are kept after a run, so the same block can be encrypted again without reloading it.

Top module: `lwc_encrypt`

## Requirements
- R1: An active-high synchronous reset drives `ready` and `dout` to 0 and clears the staged key and plaintext to 0. Reset also aborts any run in progress.
- R2: Command 1 writes `din` to key bits 31:0 and command 2 writes it to key bits 63:32. Command 3 writes `din[31:16]` to key bits 79:64; `din[15:0]` is ignored for that command.
- R3: Command 4 writes `din` to plaintext bits 31:0 and command 5 writes it to plaintext bits 63:32.
- R4: Command 6, issued while no run is in progress, starts a run on the staged values. `ready` is 0 after the edge that accepts the command and after each of the next 31 edges. `ready` is 1 after the 32nd edge following the accepting edge.
- R5: The result is the PRESENT-80 ciphertext, computed as follows. Each of the 31 rounds XORs the top 64 key-register bits into the state. It then applies the S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 to every nibble, then moves bit i to bit 16·i mod 63 (bit 63 stays in place). After each round, the key register is rotated left by 61, its top nibble is passed through the S-box, and the round number is XORed into bits 19:15. A final XOR with the top 64 key bits ends the run.
- R6: While `ready` is 1, command 7 loads ciphertext bits 31:0 into `dout` and command 8 loads bits 63:32, each at the next edge. `dout` holds its value at every other edge.
- R7: While a run is in progress, commands 1–6 have no effect on the staged values or on the run.
- R8: Command 0 and commands 9–15 have no effect.
- R9: Once `ready` is 1, it stays 1 until a run command is accepted, even if load or read commands arrive in the meantime.
- R10: Staged key and plaintext persist across runs, so repeating command 6 without reloading yields the same ciphertext.
- R11: Commands 7 and 8 are ignored while `ready` is 0, and `dout` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Data word accompanying a load command |
| cmd | input | 4 | Command code sampled each clock |
| dout | output | 32 | Selected ciphertext word |
| ready | output | 1 | Ciphertext available |

## Verification
The hardest situation to reach is a command arriving in the middle of a run. Such a command must not alter the staged values, the running computation or the output register, and its only visible effect comes much later, in the ciphertext. The stimulus therefore drives random command codes with random data on every clock of selected runs. It then compares the result against a model fed only with the values staged before the run. A reset issued mid-run, followed by an encryption of the cleared staging registers, covers the abort path.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  localparam int WORD_W = 32;
  localparam int CMD_W  = 4;
  localparam int BLK_W  = 64;
  localparam int KEY_W  = 80;
  localparam int RC_W   = 5;
  localparam int NIBS   = BLK_W / 4;

  typedef enum logic [CMD_W-1:0] {
    OP_NONE  = 4'd0,
    OP_KEYA  = 4'd1,
    OP_KEYB  = 4'd2,
    OP_KEYC  = 4'd3,
    OP_TXTA  = 4'd4,
    OP_TXTB  = 4'd5,
    OP_RUN   = 4'd6,
    OP_RDLO  = 4'd7,
    OP_RDHI  = 4'd8
  } op_e;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] sub_layer(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int n = 0; n < NIBS; n++) r[4*n +: 4] = sbox4(s[4*n +: 4]);
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] perm_layer(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int i = 0; i < BLK_W - 1; i++) r[(16 * i) % (BLK_W - 1)] = s[i];
    r[BLK_W-1] = s[BLK_W-1];
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] round_fn(input logic [BLK_W-1:0] s,
                                                 input logic [BLK_W-1:0] rk);
    return perm_layer(sub_layer(s ^ rk));
  endfunction

  function automatic logic [KEY_W-1:0] key_step(input logic [KEY_W-1:0] k,
                                                 input logic [RC_W-1:0] rc);
    logic [KEY_W-1:0] r;
    r = {k[18:0], k[KEY_W-1:19]};
    r[KEY_W-1 -: 4] = sbox4(r[KEY_W-1 -: 4]);
    r[19:15] = r[19:15] ^ rc;
    return r;
  endfunction
endpackage

// File: rtl/lwc_stage.sv
module lwc_stage
  import lwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ok,
  input  logic              wr_key_a,
  input  logic              wr_key_b,
  input  logic              wr_key_c,
  input  logic              wr_txt_a,
  input  logic              wr_txt_b,
  input  logic [WORD_W-1:0] din,
  output logic [KEY_W-1:0]  key_stg,
  output logic [BLK_W-1:0]  txt_stg
);
  logic any_wr;
  assign any_wr = wr_key_a | wr_key_b | wr_key_c | wr_txt_a | wr_txt_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_stg <= '0;
      txt_stg <= '0;
    end else if (load_ok) begin
      if (wr_key_a) key_stg[31:0]  <= din;
      if (wr_key_b) key_stg[63:32] <= din;
      if (wr_key_c) key_stg[79:64] <= din[31:16];
      if (wr_txt_a) txt_stg[31:0]  <= din;
      if (wr_txt_b) txt_stg[63:32] <= din;
    end
  end

  // R7
  locked_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_ok && any_wr) |=> ($stable(key_stg) && $stable(txt_stg)));
endmodule

// File: rtl/lwc_core.sv
module lwc_core
  import lwc_pkg::*;
#(
  parameter int NUM_ROUNDS = 31
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  input  logic [BLK_W-1:0] txt_in,
  output logic             busy,
  output logic             ready,
  output logic [BLK_W-1:0] result
);
  localparam int CNT_W = $clog2(NUM_ROUNDS + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS + 1);

  logic [CNT_W-1:0] rc;
  logic [KEY_W-1:0] kreg;
  logic [BLK_W-1:0] st;
  logic [BLK_W-1:0] rkey;
  logic             finish;

  assign rkey   = kreg[KEY_W-1 -: BLK_W];
  assign finish = busy && (rc == LAST);
  assign result = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ready <= 1'b0;
      rc    <= '0;
      kreg  <= '0;
      st    <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ready <= 1'b0;
      rc    <= CNT_W'(1);
      kreg  <= key_in;
      st    <= txt_in;
    end else if (finish) begin
      st    <= st ^ rkey;
      busy  <= 1'b0;
      ready <= 1'b1;
    end else if (busy) begin
      st   <= round_fn(st, rkey);
      kreg <= key_step(kreg, rc[RC_W-1:0]);
      rc   <= rc + CNT_W'(1);
    end
  end

  // R4
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !ready));
  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(rc) == LAST));
  // R7
  busy_excl_ready_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready);
endmodule

// File: rtl/lwc_out.sv
module lwc_out
  import lwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [BLK_W-1:0]  result,
  output logic [WORD_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)                dout <= '0;
    else if (ready && rd_lo) dout <= result[WORD_W-1:0];
    else if (ready && rd_hi) dout <= result[BLK_W-1:WORD_W];
  end

  // R6 R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready || !(rd_lo || rd_hi)) |=> $stable(dout));
endmodule

// File: rtl/lwc_encrypt.sv
module lwc_encrypt
  import lwc_pkg::*;
#(
  parameter int NUM_ROUNDS = 31
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic [CMD_W-1:0]  cmd,
  output logic [WORD_W-1:0] dout,
  output logic              ready
);
  logic busy, load_ok, start, rd_lo, rd_hi;
  logic [KEY_W-1:0] key_stg;
  logic [BLK_W-1:0] txt_stg;
  logic [BLK_W-1:0] result;

  assign load_ok = !busy;
  assign start   = (cmd == OP_RUN) && !busy;
  assign rd_lo   = (cmd == OP_RDLO);
  assign rd_hi   = (cmd == OP_RDHI);

  lwc_stage u_stage (
    .clk(clk), .rst(rst), .load_ok(load_ok),
    .wr_key_a(cmd == OP_KEYA), .wr_key_b(cmd == OP_KEYB), .wr_key_c(cmd == OP_KEYC),
    .wr_txt_a(cmd == OP_TXTA), .wr_txt_b(cmd == OP_TXTB),
    .din(din), .key_stg(key_stg), .txt_stg(txt_stg)
  );

  lwc_core #(.NUM_ROUNDS(NUM_ROUNDS)) u_core (
    .clk(clk), .rst(rst), .start(start), .key_in(key_stg), .txt_in(txt_stg),
    .busy(busy), .ready(ready), .result(result)
  );

  lwc_out u_out (
    .clk(clk), .rst(rst), .ready(ready), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .result(result), .dout(dout)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ready && !busy && dout == '0));
endmodule

// File: tb/sim_lwc_encrypt.sv
module sim_lwc_encrypt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic [3:0]  cmd = '0;
  logic [31:0] dout;
  logic        ready;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_dout = '0;

  lwc_encrypt u0 (.clk(clk), .rst(rst), .din(din), .cmd(cmd), .dout(dout), .ready(ready));

  always #5 clk = ~clk;

  localparam logic [63:0] SB_TAB = 64'h21748FE3DA09B65C;

  function automatic logic [3:0] b_sb(input logic [3:0] x);
    return SB_TAB[x*4 +: 4];
  endfunction

  function automatic logic [63:0] b_round(input logic [63:0] s, input logic [63:0] rk);
    logic [63:0] t, o;
    t = s ^ rk;
    for (int n = 0; n < 16; n++) t[4*n +: 4] = b_sb(t[4*n +: 4]);
    for (int j = 0; j < 64; j++) o[j] = (j == 63) ? t[63] : t[(j * 4) % 63];
    return o;
  endfunction

  function automatic logic [63:0] b_enc(input logic [79:0] key, input logic [63:0] pt);
    logic [79:0] k;
    logic [63:0] s;
    k = key; s = pt;
    for (int r = 1; r <= 31; r++) begin
      s = b_round(s, k[79:16]);
      k = {k[18:0], k[79:19]};
      k[79:76] = b_sb(k[79:76]);
      k[19:15] = k[19:15] ^ 5'(r);
    end
    return s ^ k[79:16];
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [31:0] d);
    @(negedge clk); cmd = c; din = d;
    @(posedge clk); #1 cmd = 4'd0;
  endtask

  // R2 R3: key words low first, third word upper half only
  task automatic load_all(input logic [79:0] k, input logic [63:0] p);
    send(4'd0, $urandom);
    send(4'd1, k[31:0]);
    send(4'd2, k[63:32]);
    send(4'd3, {k[79:64], 16'($urandom)});
    send(4'd4, p[31:0]);
    send(4'd5, p[63:32]);
  endtask

  // R4 timing; R7 R11 via noise during the run
  task automatic run_enc(input bit noise);
    send(4'd6, $urandom);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk("R4 ready low during run", {63'd0, ready}, 64'd0);
      if (noise) begin cmd = 4'($urandom); din = $urandom; end
      @(posedge clk); #1 cmd = 4'd0;
    end
    @(negedge clk);
    chk("R4 ready high after 32 edges", {63'd0, ready}, 64'd1);
    chk("R11 dout kept through run", {32'd0, dout}, {32'd0, exp_dout});
  endtask

  task automatic read_check(input logic [63:0] e, input string req);
    send(4'd7, $urandom);
    @(negedge clk);
    chk({req, " R6 low word"}, {32'd0, dout}, {32'd0, e[31:0]});
    send(4'd8, $urandom);
    @(negedge clk);
    chk({req, " R6 high word"}, {32'd0, dout}, {32'd0, e[63:32]});
    exp_dout = e[63:32];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [79:0] k;
    logic [63:0] p, e;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready after reset", {63'd0, ready}, 64'd0);
    chk("R1 dout after reset", {32'd0, dout}, 64'd0);
    rst = 1'b0;

    // R11: reads before any result leave dout at 0
    send(4'd7, 32'h1);
    send(4'd8, 32'h2);
    @(negedge clk);
    chk("R11 read while not ready", {32'd0, dout}, 64'd0);

    // R5 known answers
    load_all(80'd0, 64'd0);
    run_enc(1'b0);
    read_check(64'h5579C1387B228445, "R5 zero key/zero text");
    load_all({80{1'b1}}, 64'd0);
    run_enc(1'b0);
    read_check(64'hE72C46C0F5945049, "R5 R2 ones key");
    load_all(80'd0, {64{1'b1}});
    run_enc(1'b1);
    read_check(64'hA112FFC72F68417B, "R5 R3 R7 ones text");

    // R5 R7 random blocks, noise on alternate runs
    for (int t = 0; t < 8; t++) begin
      k = {16'($urandom), $urandom, $urandom};
      p = {$urandom, $urandom};
      load_all(k, p);
      run_enc(t[0]);
      e = b_enc(k, p);
      read_check(e, "R5 R7 random");
    end

    // R10 rerun without reload
    run_enc(1'b1);
    read_check(e, "R10 rerun");

    // R8 R9: unused codes and new loads while ready
    for (int c = 9; c < 16; c++) send(4'(c), $urandom);
    send(4'd0, $urandom);
    @(negedge clk);
    chk("R9 ready kept after unused codes", {63'd0, ready}, 64'd1);
    chk("R8 dout unchanged", {32'd0, dout}, {32'd0, exp_dout});
    run_enc(1'b0);
    read_check(e, "R8 staging untouched");
    k = {16'($urandom), $urandom, $urandom};
    p = {$urandom, $urandom};
    load_all(k, p);
    @(negedge clk);
    chk("R9 ready kept after loads", {63'd0, ready}, 64'd1);
    read_check(e, "R9 old result kept");
    run_enc(1'b1);
    read_check(b_enc(k, p), "R2 R3 new staging");

    // R1 reset mid-run
    send(4'd6, 32'h0);
    repeat (10) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready after mid-run reset", {63'd0, ready}, 64'd0);
    chk("R1 dout after mid-run reset", {32'd0, dout}, 64'd0);
    rst = 1'b0;
    exp_dout = '0;
    run_enc(1'b0);
    read_check(64'h5579C1387B228445, "R1 staging cleared");

    summary();
    $finish;
  end
endmodule